// File: doc/BRIEF.md
# Serial EEPROM Node-Address Fetcher

This block is an SPI master that fetches a factory-programmed node identifier from a 256-byte serial EEPROM. A one-cycle `start` pulse makes it pull chip select low and send the read opcode and a fixed start address. It then reads the top bytes of the array in one continuous burst and assembles the identifier from them. When the transfer is over it raises `done` for one cycle. The identifier outputs keep their values until the next transfer completes.

A parameter selects which kind of device is fitted. With the 48-bit kind, the six top bytes hold a 24-bit vendor prefix and a 24-bit extension. From these the block also builds a 64-bit identifier by inserting the filler 0xFFFE between the prefix and the extension. With the 64-bit kind, the eight top bytes are the identifier itself. In that case a flag marks an extension whose first sixteen bits hold a value kept for encapsulated 48-bit identifiers.

The serial clock comes from the system clock through a parameterised divider. The bus runs in mode 0: SCK idles low, data goes out on SCK falling edges, and data is sampled on SCK rising edges.

Top module: `node_id_fetcher`

## Requirements
- R1: After reset, and whenever no transfer is running, `spi_cs_n` is 1, `spi_sck` is 0 and `done` is 0. All identifier outputs and the flag are 0 until the first transfer completes.
- R2: A transfer sends the opcode 0x03 and then the start address, both MSB first. The start address is 0xFA in 48-bit mode and 0xF8 in 64-bit mode. `spi_mosi` changes only while SCK is low, so it is stable whenever SCK is high.
- R3: SCK idles low. Each SCK high phase and low phase lasts exactly `CLK_DIV` system cycles. The first rising edge comes `CLK_DIV` cycles after chip select falls.
- R4: `spi_cs_n` stays low for one unbroken burst of 16 + 8·N SCK pulses, where N is 6 in 48-bit mode and 8 in 64-bit mode. Chip select rises on the same clock edge as the last SCK falling edge.
- R5: In 48-bit mode, `id_raw[47:0]` holds the six bytes read, with the byte from the lowest address in bits 47:40 and later bytes following in address order. `id_raw[63:48]` is 0.
- R6: In 48-bit mode, `id_eui64` is the 24-bit prefix (the first three bytes read), then 0xFF, then 0xFE, then the 24-bit extension (the last three bytes read).
- R7: In 64-bit mode, `id_raw` holds the eight bytes read, with the lowest address in bits 63:56. `id_eui64` equals `id_raw`.
- R8: `ext_reserved` is 1 only in 64-bit mode, and only when `id_raw[39:24]` (the first two extension bytes) is 0xFFFE or 0xFFFF. In 48-bit mode it is always 0.
- R9: `done` is a single-cycle pulse. The identifier outputs and the flag take their new values on the same clock edge that raises `done`, and do not change in any other cycle.
- R10: A `start` pulse that arrives while a transfer is running is ignored. The running transfer is neither restarted nor lengthened, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch (used only while idle) |
| done | output | 1 | One-cycle pulse when the identifier is ready |
| spi_cs_n | output | 1 | Chip select to the EEPROM, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Command and address bits to the EEPROM |
| spi_miso | input | 1 | Data bits from the EEPROM |
| id_raw | output | 64 | Identifier as read (48 bits right-aligned in 48-bit mode) |
| id_eui64 | output | 64 | 64-bit identifier (encapsulated in 48-bit mode) |
| ext_reserved | output | 1 | Extension starts with a reserved value (64-bit mode) |

## Verification
All results are due on the same edge. If `start` is sampled on edge s, then `done`, the new identifier values and the rise of chip select all appear 2·`CLK_DIV`·(16 + 8·N) edges after s. `done` falls one edge later. The bench drives inputs and samples outputs on falling clock edges and counts edges from s. It requires `done` on exactly the due count, and only then compares the outputs against bytes it computes itself from the memory model's address formula. It checks the following edge for the end of the pulse and for unchanged outputs, and reads the opcode, address, pulse count and chip-select count that the model recorded over the whole burst.

// File: rtl/nid_pkg.sv
package nid_pkg;

   localparam logic [7:0]  NID_READ_OP = 8'h03;
   localparam logic [15:0] NID_FILLER  = 16'hFFFE;

   typedef enum logic {
      NID_IDLE = 1'b0,
      NID_XFER = 1'b1
   } nid_state_e;

   // First two extension bytes equal to 0xFFFE or 0xFFFF
   function automatic logic nid_is_reserved(input logic [15:0] v);
      return v[15:1] == 15'h7FFF;
   endfunction

endpackage

// File: rtl/nid_clkdiv.sv
module nid_clkdiv #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end

         assign tick = run && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/nid_shift.sv
module nid_shift #(
   parameter int CMD_W = 16,
   parameter int RX_W  = 48,
   parameter int TOTAL = CMD_W + RX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] cmd,
   input  logic             rise,
   input  logic             fall,
   input  logic             miso,
   output logic             mosi,
   output logic [RX_W-1:0]  rx,
   output logic             last
);

   localparam int BW = $clog2(TOTAL + 1);
   localparam logic [BW-1:0] LAST_IDX = BW'(TOTAL - 1);

   logic [CMD_W-1:0] tx;
   logic [BW-1:0]    bitn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx   <= '0;
         bitn <= '0;
      end else if (load) begin
         tx   <= cmd;
         bitn <= '0;
      end else if (fall) begin
         tx   <= {tx[CMD_W-2:0], 1'b0};
         bitn <= bitn + BW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx <= '0;
      end else if (rise) begin
         rx <= {rx[RX_W-2:0], miso};
      end
   end

   assign mosi = tx[CMD_W-1];
   assign last = (bitn == LAST_IDX);

endmodule

// File: rtl/nid_assemble.sv
module nid_assemble
   import nid_pkg::*;
#(
   parameter int WIDE_ID = 0,
   parameter int RX_W    = 48
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [RX_W-1:0] rx,
   output logic [63:0]     id_raw,
   output logic [63:0]     id_eui64,
   output logic            ext_reserved
);

   generate
      if (WIDE_ID != 0) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_raw       <= '0;
               id_eui64     <= '0;
               ext_reserved <= 1'b0;
            end else if (capture) begin
               id_raw       <= 64'(rx);
               id_eui64     <= 64'(rx);
               ext_reserved <= nid_is_reserved(rx[39:24]);
            end
         end
      end else begin : g_narrow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_raw       <= '0;
               id_eui64     <= '0;
               ext_reserved <= 1'b0;
            end else if (capture) begin
               id_raw       <= {16'h0000, rx[47:0]};
               id_eui64     <= {rx[47:24], NID_FILLER, rx[23:0]};
               ext_reserved <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/node_id_fetcher.sv
module node_id_fetcher
   import nid_pkg::*;
#(
   parameter int WIDE_ID = 0,
   parameter int CLK_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   output logic        done,
   output logic        spi_cs_n,
   output logic        spi_sck,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic [63:0] id_raw,
   output logic [63:0] id_eui64,
   output logic        ext_reserved
);

   localparam int NBYTES = (WIDE_ID != 0) ? 8 : 6;
   localparam int RX_W   = 8 * NBYTES;
   localparam int CMD_W  = 16;
   localparam int TOTAL  = CMD_W + RX_W;
   localparam logic [7:0] START_ADDR = 8'(256 - NBYTES);

   if (WIDE_ID < 0 || WIDE_ID > 1) begin : g_bad_mode
      $error("WIDE_ID must be 0 or 1");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end

   nid_state_e      state;
   logic            tick;
   logic            rise;
   logic            fall;
   logic            load;
   logic            last;
   logic            capture;
   logic [RX_W-1:0] rx;

   assign load    = (state == NID_IDLE) && start;
   assign rise    = (state == NID_XFER) && tick && !spi_sck;
   assign fall    = (state == NID_XFER) && tick &&  spi_sck;
   assign capture = fall && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= NID_IDLE;
         spi_cs_n <= 1'b1;
         spi_sck  <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            NID_IDLE: begin
               if (start) begin
                  state    <= NID_XFER;
                  spi_cs_n <= 1'b0;
               end
            end
            NID_XFER: begin
               if (rise) begin
                  spi_sck <= 1'b1;
               end else if (fall) begin
                  spi_sck <= 1'b0;
                  if (last) begin
                     state    <= NID_IDLE;
                     spi_cs_n <= 1'b1;
                     done     <= 1'b1;
                  end
               end
            end
            default: state <= NID_IDLE;
         endcase
      end
   end

   nid_clkdiv #(.DIV(CLK_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == NID_XFER),
      .tick  (tick)
   );

   nid_shift #(.CMD_W(CMD_W), .RX_W(RX_W), .TOTAL(TOTAL)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .cmd   ({NID_READ_OP, START_ADDR}),
      .rise  (rise),
      .fall  (fall),
      .miso  (spi_miso),
      .mosi  (spi_mosi),
      .rx    (rx),
      .last  (last)
   );

   nid_assemble #(.WIDE_ID(WIDE_ID), .RX_W(RX_W)) u_asm (
      .clk          (clk),
      .rst_n        (rst_n),
      .capture      (capture),
      .rx           (rx),
      .id_raw       (id_raw),
      .id_eui64     (id_eui64),
      .ext_reserved (ext_reserved)
   );

endmodule

// File: rtl/nid_checker.sv
module nid_checker #(
   parameter int WIDE_ID = 0,
   parameter int CLK_DIV = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        done,
   input logic        spi_cs_n,
   input logic        spi_sck,
   input logic        spi_mosi,
   input logic [63:0] id_raw,
   input logic [63:0] id_eui64,
   input logic        ext_reserved
);

   logic        sck_d;
   logic [15:0] hp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         hp    <= '0;
      end else begin
         sck_d <= spi_sck;
         if (spi_sck != sck_d) begin
            hp <= 16'd1;
         end else if (hp != 16'hFFFF) begin
            hp <= hp + 16'd1;
         end
      end
   end

   a_r1_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && sck_d) |-> $stable(spi_mosi));

   a_r3_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_d && !spi_sck) |-> (hp == 16'(CLK_DIV)));

   a_r4_cs_up_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> spi_cs_n);

   a_r6_filler_inserted: assert property (@(posedge clk) disable iff (!rst_n)
      (done && WIDE_ID == 0) |-> (id_eui64[39:24] == 16'hFFFE && id_raw[63:48] == 16'h0000));

   a_r7_wide_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (done && WIDE_ID != 0) |-> (id_eui64 == id_raw));

   a_r8_flag_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
      (WIDE_ID == 0) |-> !ext_reserved);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(id_raw) && $stable(id_eui64) && $stable(ext_reserved)));

endmodule

bind node_id_fetcher nid_checker #(.WIDE_ID(WIDE_ID), .CLK_DIV(CLK_DIV)) u_nid_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .done         (done),
   .spi_cs_n     (spi_cs_n),
   .spi_sck      (spi_sck),
   .spi_mosi     (spi_mosi),
   .id_raw       (id_raw),
   .id_eui64     (id_eui64),
   .ext_reserved (ext_reserved)
);

// File: tb/tb_node_id_fetcher.sv
`timescale 1ns/1ps

package nid_tb_pkg;
   // Memory contents of the bench EEPROM, a pure function of address
   function automatic logic [7:0] mem_byte(input logic [7:0] seed, input logic [1:0] res,
                                           input logic [7:0] a);
      if (res == 2'd1 && a == 8'hFB) return 8'hFF;
      if (res == 2'd1 && a == 8'hFC) return 8'hFE;
      if (res == 2'd2 && (a == 8'hFB || a == 8'hFC)) return 8'hFF;
      if (res == 2'd3 && a == 8'hFB) return 8'hFF;
      if (res == 2'd3 && a == 8'hFC) return 8'hFD;
      return 8'((a * 8'd29) ^ (seed * 8'd7) ^ 8'h5A);
   endfunction
endpackage

module nid_eeprom_model
   import nid_tb_pkg::*;
(
   input  logic       cs_n,
   input  logic       sck,
   input  logic       mosi,
   output logic       miso,
   input  logic [7:0] seed,
   input  logic [1:0] res,
   output int         rises,
   output int         cs_falls,
   output logic [7:0] op,
   output logic [7:0] addr
);
   int bitc = 0;

   initial begin
      miso = 1'b0; rises = 0; cs_falls = 0; op = '0; addr = '0;
   end

   always @(negedge cs_n) begin
      bitc = 0; rises = 0; op = '0; addr = '0;
      cs_falls = cs_falls + 1;
   end

   always @(posedge sck) begin
      if (!cs_n) begin
         if (bitc < 8)       op   = {op[6:0], mosi};
         else if (bitc < 16) addr = {addr[6:0], mosi};
         bitc  = bitc + 1;
         rises = rises + 1;
      end
   end

   always @(negedge sck) begin
      if (!cs_n && bitc >= 16) begin
         logic [7:0] b;
         b    = mem_byte(seed, res, 8'(addr + 8'((bitc - 16) / 8)));
         miso = b[7 - ((bitc - 16) % 8)];
      end
   end
endmodule

module tb_node_id_fetcher;
   import nid_tb_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic        start48 = 0, start64 = 0;
   logic        done48, done64, cs48, cs64, sck48, sck64, mosi48, mosi64, miso48, miso64;
   logic [63:0] raw48, raw64, eui48, eui64;
   logic        res48f, res64f;
   logic [7:0]  seed48 = 0, seed64 = 0, op48, op64, ad48, ad64;
   logic [1:0]  rm48 = 0, rm64 = 0;
   int          ri48, ri64, cf48, cf64;

   node_id_fetcher #(.WIDE_ID(0), .CLK_DIV(2)) dut (
      .clk(clk), .rst_n(rst_n), .start(start48), .done(done48),
      .spi_cs_n(cs48), .spi_sck(sck48), .spi_mosi(mosi48), .spi_miso(miso48),
      .id_raw(raw48), .id_eui64(eui48), .ext_reserved(res48f));

   node_id_fetcher #(.WIDE_ID(1), .CLK_DIV(3)) dut64 (
      .clk(clk), .rst_n(rst_n), .start(start64), .done(done64),
      .spi_cs_n(cs64), .spi_sck(sck64), .spi_mosi(mosi64), .spi_miso(miso64),
      .id_raw(raw64), .id_eui64(eui64), .ext_reserved(res64f));

   nid_eeprom_model m48 (.cs_n(cs48), .sck(sck48), .mosi(mosi48), .miso(miso48),
      .seed(seed48), .res(rm48), .rises(ri48), .cs_falls(cf48), .op(op48), .addr(ad48));
   nid_eeprom_model m64 (.cs_n(cs64), .sck(sck64), .mosi(mosi64), .miso(miso64),
      .seed(seed64), .res(rm64), .rises(ri64), .cs_falls(cf64), .op(op64), .addr(ad64));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic run_one(input bit w, input logic [7:0] seed, input logic [1:0] res);
      int div = w ? 3 : 2;
      int nb  = w ? 8 : 6;
      int tot = 16 + 8 * nb;
      logic [7:0]  sa = 8'(256 - nb);
      logic [63:0] raw_e = '0, eui_e, raw_a, eui_a;
      bit          flag_e, flag_a, dn, cs, sk;
      int          n, falls0, rises_a;
      logic [7:0]  op_a, ad_a;

      for (int i = 0; i < nb; i++) raw_e = {raw_e[55:0], mem_byte(seed, res, 8'(sa + 8'(i)))};
      if (w) begin
         eui_e  = raw_e;
         flag_e = (raw_e[39:24] == 16'hFFFE) || (raw_e[39:24] == 16'hFFFF);
      end else begin
         eui_e  = {raw_e[47:24], 16'hFFFE, raw_e[23:0]};
         flag_e = 1'b0;
      end

      @(negedge clk);
      if (w) begin seed64 = seed; rm64 = res; falls0 = cf64; start64 = 1; end
      else   begin seed48 = seed; rm48 = res; falls0 = cf48; start48 = 1; end
      @(negedge clk);
      start48 = 0; start64 = 0;
      n = 1;
      dn = w ? done64 : done48;
      while (!dn && n < 5000) begin
         @(negedge clk);
         n++;
         // R10: a second start pulse in the middle of the burst
         if (n == 20) begin if (w) start64 = 1; else start48 = 1; end
         if (n == 21) begin start48 = 0; start64 = 0; end
         dn = w ? done64 : done48;
      end

      raw_a = w ? raw64 : raw48;   eui_a = w ? eui64 : eui48;
      flag_a = w ? res64f : res48f; cs = w ? cs64 : cs48;
      rises_a = w ? ri64 : ri48;    op_a = w ? op64 : op48; ad_a = w ? ad64 : ad48;

      chk(n == 2 * div * tot + 1, "R3 done latency", 64'(n), 64'(2 * div * tot + 1));
      chk(cs == 1'b1, "R4 cs released with done", 64'(cs), 64'd1);
      chk(rises_a == tot, "R4 sck pulse count", 64'(rises_a), 64'(tot));
      chk(op_a == 8'h03, "R2 opcode", 64'(op_a), 64'h03);
      chk(ad_a == sa, "R2 start address", 64'(ad_a), 64'(sa));
      if (w) begin
         chk(raw_a == raw_e, "R7 wide identifier", raw_a, raw_e);
         chk(eui_a == eui_e, "R7 wide eui64 equals raw", eui_a, eui_e);
      end else begin
         chk(raw_a == raw_e, "R5 narrow identifier", raw_a, raw_e);
         chk(eui_a == eui_e, "R6 encapsulated identifier", eui_a, eui_e);
      end
      chk(flag_a == flag_e, "R8 reserved flag", 64'(flag_a), 64'(flag_e));

      @(negedge clk);
      dn = w ? done64 : done48;
      sk = w ? sck64 : sck48;
      chk(!dn, "R9 done is one cycle", 64'(dn), 64'd0);
      chk((w ? raw64 : raw48) == raw_e, "R9 identifier held", w ? raw64 : raw48, raw_e);
      chk(!sk, "R1 sck idle low", 64'(sk), 64'd0);
      // R10: the ignored start must not launch another transfer
      repeat (2 * div * 4) @(negedge clk);
      chk(((w ? cf64 : cf48) - falls0) == 1, "R10 single chip-select cycle",
          64'((w ? cf64 : cf48) - falls0), 64'd1);
      chk((w ? cs64 : cs48) == 1'b1, "R1 cs idle high", 64'(w ? cs64 : cs48), 64'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state of both configurations
      chk(cs48 && cs64, "R1 cs high after reset", 64'({cs48, cs64}), 64'd3);
      chk(!sck48 && !sck64, "R1 sck low after reset", 64'({sck48, sck64}), 64'd0);
      chk(!done48 && !done64, "R1 done low after reset", 64'({done48, done64}), 64'd0);
      chk(raw48 == 0 && raw64 == 0 && eui48 == 0 && eui64 == 0 && !res64f,
          "R1 outputs zero after reset", raw64 | raw48, 64'd0);

      for (int s = 0; s < 16; s++) begin
         for (int r = 0; r < 4; r++) begin
            run_one(1'b0, 8'(s * 17 + 3), 2'(r));
            run_one(1'b1, 8'(s * 13 + 1), 2'(r));
         end
      end
      summary();
   end
endmodule